// File: doc/BRIEF.md
# Bit-Serial Stationary-Operand Dot-Product Unit

This block holds one vector of signed 8-bit elements in local registers and computes its inner product with a second vector that streams in one bit-plane per clock. In an attention pipeline the resident vector is the query and each streamed vector is a key, so only the keys move for each product. During every slice cycle each resident element is either passed or zeroed by its key bit. A pipelined binary adder tree reduces these gated values, and a shift-accumulator weighs each slice sum by its bit position. The eighth slice carries a negative weight, which makes the key a two's-complement number. The finished sum is clamped to a signed 16-bit value and presented with a one-cycle strobe to the downstream nonlinear stage.

A small controller sequences the work through three states. `ST_IDLE` means nothing is in flight and the resident vector may be rewritten. `ST_STREAM` accepts slices 1 to 7 of the current key. `ST_DRAIN` waits for the adder tree and accumulator to empty, and it accepts a fresh start. The transitions are:
- IDLE→STREAM on an accepted start.
- STREAM→STREAM while slices remain.
- STREAM→DRAIN after slice 7.
- DRAIN→STREAM on a new start, which gives back-to-back products.
- DRAIN→DRAIN while results are pending.
- DRAIN→IDLE in the cycle after the strobe is due.

Writes to the resident vector are refused whenever the controller is not in `ST_IDLE`.

Top module: `bsdot_unit`

## Requirements
- R1: When `ld_en` is high, `start` is low and `busy` is low, element `ld_idx` takes `ld_data` at the clock edge. Every later product uses the new value.
- R2: A write request made while `busy` is high, or in the same cycle as `start`, is dropped. The resident vector is unchanged, as the next product shows.
- R3: The cycle in which `start` is accepted carries slice 0 on `key_slice`. The following seven cycles carry slices 1 to 7, least significant bit first. Bit i of `key_slice` belongs to element i.
- R4: `result` equals the sum over i of q_i·k_i. Both q_i and k_i are read as signed two's-complement 8-bit numbers, so slice 7 has weight −128.
- R5: A sum above 32767 is output as 32767. A sum below −32768 is output as −32768. The values 32767 and −32768 themselves pass through unchanged.
- R6: `res_vld` is high for exactly one cycle, 8 + log2(N_ELEM) cycles after the cycle in which start was accepted. `result` keeps its value until the next strobe.
- R7: A `start` raised while slices 1 to 7 are being taken has no effect. Only one result appears, and its value is correct.
- R8: A start raised in the cycle right after slice 7 is accepted. Products then follow every 8 cycles, and each one is correct and on time.
- R9: `busy` is high from the cycle after an accepted start through the cycle of the last pending strobe, and low in the cycle after that.
- R10: After reset, `res_vld`, `busy` and `result` are 0 and every resident element is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write request for one resident element |
| ld_idx | input | $clog2(N_ELEM) | Element index for the write |
| ld_data | input | EW | Signed value to store |
| start | input | 1 | Begin a product; this cycle carries slice 0 |
| key_slice | input | N_ELEM | One bit of each key element for the current slice |
| busy | output | 1 | A product is in flight; writes are refused |
| res_vld | output | 1 | One-cycle strobe marking a new result |
| result | output | RW | Saturated signed inner product |

## Verification
The bench builds the unit with N_ELEM = 4, so the adder tree has two levels and the strobe is due 10 cycles after start. At that size four products of −128·−128 reach 65536 and four of 127·−128 reach −65024, so both clamp limits can be hit. The exact values ±32767 and −32768 can also be placed on purpose. The size also allows every one of the 256 resident values to be swept against a spread of key patterns, with the products streamed back to back. Each strobe is checked for its value and its exact arrival cycle against sums the bench works out itself.

// File: rtl/bsdot_pkg.sv
package bsdot_pkg;

    // Controller states of the dot-product unit
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } bsdot_state_e;

endpackage

// File: rtl/bsdot_store.sv
module bsdot_store #(
    parameter int N_ELEM = 16,
    parameter int EW     = 8,
    parameter int IDXW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDXW-1:0]        wr_idx,
    input  logic [EW-1:0]          wr_data,
    input  logic                   busy_i,
    output logic [N_ELEM*EW-1:0]   vec_o
);

    // One register per resident element
    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_o[e*EW +: EW] <= '0;
            end else if (wr_en && (wr_idx == IDXW'(e))) begin
                vec_o[e*EW +: EW] <= wr_data;
            end
        end
    end

    // R2: nothing may change the resident vector while a product is in flight
    assert_vec_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(vec_o));

endmodule

// File: rtl/bsdot_gate_tree.sv
module bsdot_gate_tree #(
    parameter int N_ELEM = 16,
    parameter int EW     = 8,
    parameter int IW     = 3,
    localparam int LV    = $clog2(N_ELEM),
    localparam int P     = 1 << LV,
    localparam int SW    = EW + LV
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic [IW-1:0]          in_idx,
    input  logic [N_ELEM*EW-1:0]   vec_i,
    input  logic [N_ELEM-1:0]      slice_i,
    output logic                   out_vld,
    output logic [IW-1:0]          out_idx,
    output logic signed [SW-1:0]   out_sum
);

    logic signed [SW-1:0] leaf  [P];
    logic signed [SW-1:0] inner [P-1];
    logic                 tag_vld [LV];
    logic [IW-1:0]        tag_idx [LV];

    // Gating: each element passes only when its key bit is set; padding leaves are zero
    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < N_ELEM) begin : g_real
            always_comb begin
                leaf[j] = slice_i[j] ? SW'($signed(vec_i[j*EW +: EW])) : '0;
            end
        end else begin : g_pad
            always_comb begin
                leaf[j] = '0;
            end
        end
    end

    // Heap-ordered tree; every internal node is a register, so depth equals LV
    for (genvar k = 0; k < P - 1; k++) begin : g_node
        localparam int C0 = 2 * k + 1;
        localparam int C1 = 2 * k + 2;
        if (C0 >= P - 1) begin : g_from_leaf
            always_ff @(posedge clk) begin
                if (!rst_n) inner[k] <= '0;
                else        inner[k] <= leaf[C0-(P-1)] + leaf[C1-(P-1)];
            end
        end else begin : g_from_node
            always_ff @(posedge clk) begin
                if (!rst_n) inner[k] <= '0;
                else        inner[k] <= inner[C0] + inner[C1];
            end
        end
    end

    // Slice tags travel alongside the partial sums
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LV; s++) begin
                tag_vld[s] <= 1'b0;
                tag_idx[s] <= '0;
            end
        end else begin
            tag_vld[0] <= in_vld;
            tag_idx[0] <= in_idx;
            for (int s = 1; s < LV; s++) begin
                tag_vld[s] <= tag_vld[s-1];
                tag_idx[s] <= tag_idx[s-1];
            end
        end
    end

    assign out_vld = tag_vld[LV-1];
    assign out_idx = tag_idx[LV-1];
    assign out_sum = inner[0];

endmodule

// File: rtl/bsdot_shift_acc.sv
module bsdot_shift_acc #(
    parameter int SW  = 12,
    parameter int KW  = 8,
    parameter int IW  = 3,
    parameter int RW  = 16,
    localparam int AW = SW + KW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic [IW-1:0]          in_idx,
    input  logic signed [SW-1:0]   in_sum,
    output logic                   res_vld,
    output logic [RW-1:0]          res
);

    localparam logic signed [AW-1:0] RMAX = {{(AW-RW+1){1'b0}}, {(RW-1){1'b1}}};
    localparam logic signed [AW-1:0] RMIN = {{(AW-RW+1){1'b1}}, {(RW-1){1'b0}}};

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] term;
    logic signed [AW-1:0] total;
    logic signed [AW-1:0] clipped;
    logic                 is_last;

    always_comb begin
        is_last = (in_idx == IW'(KW - 1));
        term    = AW'(in_sum) <<< in_idx;
        if (is_last) begin
            term = -term;              // sign slice of the key weighs negative
        end
        total = acc + term;
        if (total > RMAX)      clipped = RMAX;
        else if (total < RMIN) clipped = RMIN;
        else                   clipped = total;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= 1'b0;
            if (in_vld) begin
                if (in_idx == '0) acc <= term;
                else              acc <= total;
                if (is_last) begin
                    res     <= clipped[RW-1:0];
                    res_vld <= 1'b1;
                end
            end
        end
    end

    // R3: slices reach the accumulator in order, one per cycle
    assert_slice_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_idx != '0) |-> ($past(in_vld) && $past(in_idx) == IW'(in_idx - 1'b1)));

endmodule

// File: rtl/bsdot_unit.sv
module bsdot_unit
    import bsdot_pkg::*;
#(
    parameter int N_ELEM = 16,
    parameter int EW     = 8,
    parameter int KW     = 8,
    parameter int RW     = 16,
    localparam int IDXW  = $clog2(N_ELEM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [IDXW-1:0]      ld_idx,
    input  logic [EW-1:0]        ld_data,
    input  logic                 start,
    input  logic [N_ELEM-1:0]    key_slice,
    output logic                 busy,
    output logic                 res_vld,
    output logic [RW-1:0]        result
);

    localparam int LV = $clog2(N_ELEM);
    localparam int IW = $clog2(KW);
    localparam int SW = EW + LV;
    localparam int CW = $clog2(KW + LV + 2);

    bsdot_state_e         state, state_nx;
    logic [CW-1:0]        cnt, cnt_nx;
    logic                 take_start;
    logic                 slice_vld;
    logic [IW-1:0]        slice_idx;
    logic                 wr_en;
    logic [N_ELEM*EW-1:0] vec;
    logic                 t_vld;
    logic [IW-1:0]        t_idx;
    logic signed [SW-1:0] t_sum;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_STREAM;
                    cnt_nx   = CW'(1);
                end
            end
            ST_STREAM: begin
                if (cnt == CW'(KW - 1)) begin
                    state_nx = ST_DRAIN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (start) begin
                    state_nx = ST_STREAM;
                    cnt_nx   = CW'(1);
                end else if (cnt == CW'(LV)) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs of the controller
    always_comb begin
        take_start = 1'b0;
        slice_vld  = 1'b0;
        slice_idx  = '0;
        wr_en      = 1'b0;
        busy       = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy       = 1'b0;
                take_start = start;
                slice_vld  = start;
                wr_en      = ld_en && !start;
            end
            ST_STREAM: begin
                slice_vld = 1'b1;
                slice_idx = cnt[IW-1:0];
            end
            ST_DRAIN: begin
                take_start = start;
                slice_vld  = start;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

    bsdot_store #(
        .N_ELEM (N_ELEM),
        .EW     (EW),
        .IDXW   (IDXW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ld_idx),
        .wr_data (ld_data),
        .busy_i  (busy || start),
        .vec_o   (vec)
    );

    bsdot_gate_tree #(
        .N_ELEM (N_ELEM),
        .EW     (EW),
        .IW     (IW)
    ) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (slice_vld),
        .in_idx  (slice_idx),
        .vec_i   (vec),
        .slice_i (key_slice),
        .out_vld (t_vld),
        .out_idx (t_idx),
        .out_sum (t_sum)
    );

    bsdot_shift_acc #(
        .SW (SW),
        .KW (KW),
        .IW (IW),
        .RW (RW)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (t_vld),
        .in_idx  (t_idx),
        .in_sum  (t_sum),
        .res_vld (res_vld),
        .res     (result)
    );

    // R6: the strobe never lasts longer than one cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    // R9: a result can only emerge while the controller reports work in flight
    assert_busy_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> busy);

    // R7: a start during streaming leaves the slice sequence running
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && cnt != CW'(KW - 1)) |=> (state == ST_STREAM && cnt == $past(cnt) + 1'b1));

    // R8: the sign slice hands over to a state that can take a new start at once
    assert_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && cnt == CW'(KW - 1)) |=> (state == ST_DRAIN));

endmodule

// File: tb/sim_bsdot_unit.sv
module sim_bsdot_unit;

    localparam int NB  = 4;
    localparam int EW  = 8;
    localparam int KW  = 8;
    localparam int RW  = 16;
    localparam int LB  = $clog2(NB);
    localparam int LAT = KW + LB;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_en = 1'b0;
    logic [LB-1:0]    ld_idx = '0;
    logic [EW-1:0]    ld_data = '0;
    logic             start = 1'b0;
    logic [NB-1:0]    key_slice = '0;
    logic             busy;
    logic             res_vld;
    logic [RW-1:0]    result;

    always #2.5 clk = ~clk;

    bsdot_unit #(.N_ELEM(NB), .EW(EW), .KW(KW), .RW(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .start(start), .key_slice(key_slice), .busy(busy), .res_vld(res_vld), .result(result)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    logic [EW-1:0] qm [NB];
    int exp_val[$];
    int exp_time[$];
    int exp_tag[$];
    int inj_ld = -1;
    int inj_st = -1;
    logic [EW-1:0] inj_val = '0;
    bit chk_busy = 0;
    bit done = 0;

    function automatic int model(input logic [NB*EW-1:0] kv);
        int s = 0;
        for (int i = 0; i < NB; i++) begin
            s += int'($signed(qm[i])) * int'($signed(kv[i*EW +: EW]));
        end
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Result monitor: value and arrival cycle (R4, R5, R6, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_time.size() > 0 && exp_time[0] == cyc) begin
                check(res_vld == 1'b1, $sformatf("R%0d strobe", exp_tag[0]), int'(res_vld), 1);
                check(int'($signed(result)) == exp_val[0], $sformatf("R%0d value", exp_tag[0]),
                      int'($signed(result)), exp_val[0]);
                void'(exp_time.pop_front());
                void'(exp_val.pop_front());
                void'(exp_tag.pop_front());
            end else if (res_vld) begin
                check(1'b0, "R6/R7 unexpected strobe", 1, 0);
            end
        end
    end

    // Stream one key, LSB slice first (R3)
    task automatic do_dot(input logic [NB*EW-1:0] kv, input int tag);
        exp_val.push_back(model(kv));
        exp_time.push_back(cyc + LAT);
        exp_tag.push_back(tag);
        for (int s = 0; s < KW; s++) begin
            start   = (s == 0) || (s == inj_st);
            ld_en   = (s == inj_ld);
            ld_idx  = '0;
            ld_data = inj_val;
            for (int i = 0; i < NB; i++) key_slice[i] = kv[i*EW + s];
            @(negedge clk);
            if (s == 0 && chk_busy) check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        end
        start = 1'b0;
        ld_en = 1'b0;
        key_slice = '0;
    endtask

    task automatic load_elem(input int idx, input logic [EW-1:0] val);
        ld_en   = 1'b1;
        ld_idx  = LB'(idx);
        ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        qm[idx] = val;
    endtask

    task automatic wait_idle();
        while (exp_time.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NB*EW-1:0] pack4(input int a, input int b, input int c, input int d);
        return {EW'(d), EW'(c), EW'(b), EW'(a)};
    endfunction

    initial begin
        for (int i = 0; i < NB; i++) qm[i] = '0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(res_vld == 1'b0, "R10 res_vld", int'(res_vld), 0);
        check(busy == 1'b0, "R10 busy", int'(busy), 0);
        check(result == '0, "R10 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_dot(pack4(-1, -1, -1, -1), 10);   // R10: cleared vector gives 0
        wait_idle();

        // R3 bit order: single element, single slice
        load_elem(0, 8'd5);
        do_dot(pack4(1, 0, 0, 0), 3);
        do_dot(pack4(64, 0, 0, 0), 3);
        do_dot(pack4(-128, 0, 0, 0), 3);
        wait_idle();

        // R1 each element reachable by its index
        for (int e = 0; e < NB; e++) load_elem(e, EW'(11 * e + 3));
        for (int e = 0; e < NB; e++) begin
            logic [NB*EW-1:0] kv = '0;
            kv[e*EW +: EW] = 8'd1;
            do_dot(kv, 1);
        end
        wait_idle();

        // R4/R8 sweep: every resident value, keys streamed back to back
        for (int a = 0; a < 256; a++) begin
            for (int i = 0; i < NB; i++) load_elem(i, EW'(a + i * 85));
            for (int j = 0; j < 24; j++) begin
                do_dot(pack4((j * 11 + a * 3) & 255, (j * 37 + a + 128) & 255,
                             (j * 8 + a * 5 + 1) & 255, (255 - j * 9 - a) & 255),
                       (j == 0) ? 4 : 8);
            end
            wait_idle();
        end

        // R5 clamp limits and exact boundaries
        for (int i = 0; i < NB; i++) load_elem(i, 8'h80);
        do_dot(pack4(-128, -128, -128, -128), 5);
        do_dot(pack4(127, 127, 127, 127), 5);
        wait_idle();
        for (int i = 0; i < NB; i++) load_elem(i, 8'd127);
        do_dot(pack4(-128, -128, -128, -128), 5);
        wait_idle();
        load_elem(0, 8'h80); load_elem(1, 8'h80); load_elem(2, 8'h80); load_elem(3, 8'd0);
        do_dot(pack4(127, 127, 2, 0), 5);     // exactly -32768
        do_dot(pack4(127, 127, 3, 0), 5);     // -32896 clamps
        wait_idle();
        load_elem(0, 8'd127); load_elem(1, 8'd127); load_elem(2, 8'd127); load_elem(3, 8'd1);
        do_dot(pack4(127, 127, 4, 1), 5);     // exactly 32767
        do_dot(pack4(127, 127, 4, 2), 5);     // 32768 clamps
        wait_idle();

        // R2 write refused mid-stream, at start, and while draining
        load_elem(0, 8'd9); load_elem(1, 8'd0); load_elem(2, 8'd0); load_elem(3, 8'd0);
        inj_val = 8'h55;
        inj_ld = 3;
        do_dot(pack4(3, 0, 0, 0), 2);
        inj_ld = 0;
        do_dot(pack4(2, 0, 0, 0), 2);
        inj_ld = -1;
        ld_en = 1'b1; ld_idx = '0; ld_data = 8'h55;
        @(negedge clk);
        ld_en = 1'b0;
        wait_idle();
        do_dot(pack4(1, 0, 0, 0), 2);         // still 9 if every request was dropped
        wait_idle();

        // R7 spurious start mid-stream
        inj_st = 3;
        do_dot(pack4(7, 0, 0, 0), 7);
        inj_st = -1;
        wait_idle();
        repeat (LAT) @(negedge clk);
        check(exp_time.size() == 0 && res_vld == 1'b0, "R7 no extra result", int'(res_vld), 0);

        // R9 busy window and R6 hold
        check(busy == 1'b0, "R9 idle busy", int'(busy), 0);
        chk_busy = 1;
        do_dot(pack4(4, 0, 0, 0), 9);
        chk_busy = 0;
        check(busy == 1'b1, "R9 busy draining", int'(busy), 1);
        while (!res_vld) @(negedge clk);
        check(busy == 1'b1, "R9 busy at strobe", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R9 busy released", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(int'($signed(result)) == 36, "R6 result held", int'($signed(result)), 36);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule